// File: doc/BRIEF.md
# Serial Decimal Number Recognizer

This block watches a stream of 8-bit character codes, one per cycle in which the valid strobe is high. After each accepted character it reports whether the whole string seen since the last clear is a well-formed decimal real number. The accepted shape is an optional leading minus sign, then at least one digit. That may be followed by a point, which must itself be followed by at least one digit.

The decision is held in a six-state machine that changes only on rising clock edges. The accept output is decoded straight from the state register, so it can drive an indicator LED directly. Once a character breaks the grammar, the machine enters a sink state. It stays there until a synchronous clear or the asynchronous reset.

Top module: `numrec_top`

## Requirements
- R1: After rst_ni is asserted or clear_i is sampled high, the machine is back at the start, and accept_o is 0, because the empty string is rejected.
- R2: The character classes are fixed. Codes 0x30 to 0x39 are digits, 0x2D is the minus sign and 0x2E is the point. Every other code falls into the "other" class, and an "other" code as the first character leads to rejection.
- R3: One cycle after each clock edge that accepts a character, accept_o is 1 exactly when the accepted string matches the grammar: optional minus, one or more digits, then optionally a point and one or more digits.
- R4: On a clock edge where char_valid_i is 0 and clear_i is 0, the state does not change, whatever value char_i carries.
- R5: Once any character breaks the grammar, accept_o stays 0 for every later character until a clear or reset.
- R6: A string whose last character is a minus sign or a point is not accepted. Acceptance returns as soon as a digit follows.
- R7: Each of the following causes permanent rejection: a second point, a minus sign in any position other than the first, and a point with no digit before it.
- R8: When clear_i and char_valid_i are both high on the same edge, the clear wins and the character is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous return to the start state |
| char_valid_i | input | 1 | Strobe: char_i carries a character this cycle |
| char_i | input | CHAR_W (8) | Character code |
| accept_o | output | 1 | High while the string so far is a valid number |

## Verification
The bench builds the block with its default parameters: 8-bit codes and the standard ASCII values for the digits, the minus sign and the point. With these defaults, a sweep of all 256 codes as a first character checks every class boundary, including the codes just outside the digit range. Hand-picked strings reach every transition of the machine, including the sink state and the transitions out of it.

// File: rtl/numrec_pkg.sv
package numrec_pkg;

  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_SIGN  = 3'd1,
    ST_INT   = 3'd2,
    ST_POINT = 3'd3,
    ST_FRAC  = 3'd4,
    ST_TRAP  = 3'd5
  } nr_state_e;

  typedef struct packed {
    logic digit;
    logic minus;
    logic point;
  } nr_class_t;

endpackage

// File: rtl/numrec_char_class.sv
module numrec_char_class
  import numrec_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter logic [CHAR_W-1:0] DIGIT_LO   = CHAR_W'('h30),
  parameter logic [CHAR_W-1:0] DIGIT_HI   = CHAR_W'('h39),
  parameter logic [CHAR_W-1:0] MINUS_CODE = CHAR_W'('h2D),
  parameter logic [CHAR_W-1:0] POINT_CODE = CHAR_W'('h2E)
) (
  input  logic [CHAR_W-1:0] char_i,
  output nr_class_t         cls_o
);

  always_comb begin
    cls_o.digit = (char_i >= DIGIT_LO) && (char_i <= DIGIT_HI);
    cls_o.minus = (char_i == MINUS_CODE);
    cls_o.point = (char_i == POINT_CODE);
  end

  // classes are disjoint; a code in several classes would make the next state ambiguous
  always_comb begin
    assert_class_disjoint_R2: assert ($onehot0({cls_o.digit, cls_o.minus, cls_o.point}));
  end

endmodule

// File: rtl/numrec_next_state.sv
module numrec_next_state
  import numrec_pkg::*;
(
  input  nr_state_e state_i,
  input  nr_class_t cls_i,
  input  logic      valid_i,
  input  logic      clear_i,
  output nr_state_e state_o
);

  nr_state_e step;

  always_comb begin
    step = ST_TRAP;
    unique case (state_i)
      ST_START: begin
        if (cls_i.minus)      step = ST_SIGN;
        else if (cls_i.digit) step = ST_INT;
      end
      ST_SIGN:  if (cls_i.digit) step = ST_INT;
      ST_INT: begin
        if (cls_i.digit)      step = ST_INT;
        else if (cls_i.point) step = ST_POINT;
      end
      ST_POINT: if (cls_i.digit) step = ST_FRAC;
      ST_FRAC:  if (cls_i.digit) step = ST_FRAC;
      default:  step = ST_TRAP;
    endcase
  end

  always_comb begin
    if (clear_i)      state_o = ST_START;
    else if (valid_i) state_o = step;
    else              state_o = state_i;
  end

endmodule

// File: rtl/numrec_top.sv
module numrec_top
  import numrec_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter logic [CHAR_W-1:0] DIGIT_LO   = CHAR_W'('h30),
  parameter logic [CHAR_W-1:0] DIGIT_HI   = CHAR_W'('h39),
  parameter logic [CHAR_W-1:0] MINUS_CODE = CHAR_W'('h2D),
  parameter logic [CHAR_W-1:0] POINT_CODE = CHAR_W'('h2E)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              char_valid_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic              accept_o
);

  nr_class_t cls;
  nr_state_e state_q, state_d;

  numrec_char_class #(
    .CHAR_W    (CHAR_W),
    .DIGIT_LO  (DIGIT_LO),
    .DIGIT_HI  (DIGIT_HI),
    .MINUS_CODE(MINUS_CODE),
    .POINT_CODE(POINT_CODE)
  ) u_class (
    .char_i(char_i),
    .cls_o (cls)
  );

  numrec_next_state u_next (
    .state_i(state_q),
    .cls_i  (cls),
    .valid_i(char_valid_i),
    .clear_i(clear_i),
    .state_o(state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_START;
    else         state_q <= state_d;
  end

  assign accept_o = (state_q == ST_INT) || (state_q == ST_FRAC);

  assert_clear_rejects_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !accept_o);

  assert_idle_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !char_valid_i) |=> $stable(state_q));

  assert_accept_after_digit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(accept_o) |-> ($past(char_valid_i) && !$past(clear_i) && $past(cls.digit)));

  assert_trap_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TRAP && !clear_i) |=> (state_q == ST_TRAP));

  assert_bare_tail_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && !clear_i && (cls.minus || cls.point)) |=> !accept_o);

  assert_second_point_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FRAC && char_valid_i && !clear_i && cls.point) |=> (state_q == ST_TRAP));

  assert_clear_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && char_valid_i) |=> (state_q == ST_START));

endmodule

// File: tb/numrec_top_tb.sv
module numrec_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0;
  logic       char_valid_i = 1'b0;
  logic [7:0] char_i = 8'h00;
  logic       accept_o;

  int total = 0;
  int bad   = 0;
  byte model_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  numrec_top dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .char_valid_i(char_valid_i),
    .char_i      (char_i),
    .accept_o    (accept_o)
  );

  function automatic bit is_digit(byte c);
    return (c >= 8'h30) && (c <= 8'h39);
  endfunction

  function automatic bit model_ok();
    int i, n, d;
    i = 0;
    n = model_q.size();
    if (i < n && model_q[i] == 8'h2D) i++;
    d = 0;
    while (i < n && is_digit(model_q[i])) begin i++; d++; end
    if (d == 0) return 1'b0;
    if (i == n) return 1'b1;
    if (model_q[i] != 8'h2E) return 1'b0;
    i++;
    d = 0;
    while (i < n && is_digit(model_q[i])) begin i++; d++; end
    if (d == 0) return 1'b0;
    return i == n;
  endfunction

  task automatic check(string req);
    bit exp;
    exp = model_ok();
    total++;
    if (accept_o !== exp) begin
      bad++;
      $display("FAIL %s: accept_o=%0b expected=%0b (len=%0d)", req, accept_o, exp, model_q.size());
    end
  endtask

  // drive at negedge, model update at posedge, compare at next negedge
  task automatic cycle(byte c, bit v, bit clr, string req);
    @(negedge clk_i);
    char_i = c; char_valid_i = v; clear_i = clr;
    @(posedge clk_i);
    if (clr) model_q.delete();
    else if (v) model_q.push_back(c);
    @(negedge clk_i);
    char_valid_i = 1'b0; clear_i = 1'b0;
    check(req);
  endtask

  task automatic clr();
    cycle(8'h00, 1'b0, 1'b1, "R1");
  endtask

  task automatic feed(string s, string req);
    clr();
    for (int k = 0; k < s.len(); k++) cycle(s[k], 1'b1, 1'b0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1");

    feed("7", "R3");
    feed("-12.5", "R3");
    feed("0.0", "R3");
    feed("31415", "R3");
    feed("-0.250", "R3");
    feed("-", "R6");
    feed("3.", "R6");
    feed("-8.", "R6");
    feed("1.2.3", "R7");
    feed("1-2", "R7");
    feed("--1", "R7");
    feed(".5", "R7");
    feed("-.5", "R7");
    feed("1a23", "R5");
    feed("4.x99", "R5");
    feed(" 5", "R2");

    // R4: idle cycles with junk on the bus
    feed("9", "R4");
    for (int k = 0; k < 4; k++) cycle(8'h2E, 1'b0, 1'b0, "R4");
    cycle(8'h41, 1'b0, 1'b0, "R4");
    cycle(8'h36, 1'b1, 1'b0, "R4");
    feed("-", "R4");
    cycle(8'h37, 1'b0, 1'b0, "R4");

    // R8: clear and valid together
    feed("12", "R8");
    cycle(8'h35, 1'b1, 1'b1, "R8");
    cycle(8'h35, 1'b1, 1'b0, "R8");

    // R2: every code as a first character
    for (int c = 0; c < 256; c++) begin
      clr();
      cycle(byte'(c), 1'b1, 1'b0, "R2");
    end

    // R1: async reset mid-string
    feed("5.", "R1");
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_q.delete();
    #1 check("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    cycle(8'h38, 1'b1, 1'b0, "R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule